// File: doc/BRIEF.md
# Vector Narrowing Shift-Right Unit

This block is a registered datapath for a 128-bit vector unit. It splits a source vector into wide unsigned lanes and shifts each lane right by an immediate amount. Each shifted value is narrowed to half its width and written into an interleaved half-lane of a destination vector. Two sizes are offered: 16-bit lanes can be reduced to bytes, and 32-bit lanes can be reduced to halfwords. Every destination element the operation does not target keeps the value it had in the old destination supplied alongside the source.

Two independent single-bit selects choose among four variants per size. One select picks truncation or rounding, where rounding adds the last bit shifted out. The other select picks whether results go to the even elements (bottom) or the odd elements (top) of the destination. A 16-bit byte predicate can further suppress individual result bytes. The predicate is indexed by input lane, so each lane reads its own window of predicate bits whichever half-lane it writes. The new destination appears one clock after the operands are presented.

Top module: `vnarrow_shr`

## Requirements
- R1: While `rst_n` is low and after the first edge following its release, until new operands are registered, `result` is all zeros.
- R2: `result` changes only on a rising clock edge and then reflects the operands present at that edge; a change of operands between edges leaves `result` unchanged.
- R3: With `wide32` = 0 the source holds 8 lanes of 16 bits (lane i at bits 16i+15..16i) narrowed to bytes; with `wide32` = 1 it holds 4 lanes of 32 bits (lane i at bits 32i+31..32i) narrowed to halfwords.
- R4: With `top` = 0 lane i writes output element 2i; with `top` = 1 it writes element 2i+1 (elements are bytes when `wide32` = 0, halfwords when `wide32` = 1).
- R5: With `rnd` = 0 the written value is the low half of the unsigned lane shifted right logically by `shamt`, for `shamt` from 1 to 8 (byte results) or 1 to 16 (halfword results).
- R6: With `rnd` = 1 the written value is the low half of (x >> `shamt`) + bit (`shamt`-1) of x, the carry out of the low half being discarded; this holds up to and including `shamt` equal to the result width.
- R7: Every byte of an element not targeted by R4 equals the same byte of `dst_old`.
- R8: For byte results, lane i is written only if `pred` bit 2i is 1; for halfword results, the low byte of lane i's element is written only if `pred` bit 4i is 1 and the high byte only if bit 4i+1 is 1; a suppressed byte equals `dst_old`.
- R9: With `shamt` = 0 the written value is the low half of the lane unchanged, in both rounding and truncating modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 128 | Source vector of wide lanes |
| dst_old | input | 128 | Previous destination contents to merge with |
| shamt | input | 5 | Right shift amount |
| wide32 | input | 1 | 0: 16-to-8 narrowing, 1: 32-to-16 narrowing |
| top | input | 1 | 0: write even elements, 1: write odd elements |
| rnd | input | 1 | 0: truncate, 1: round by last bit shifted out |
| pred | input | 16 | Byte predicate, one bit per byte, indexed by input lane |
| result | output | 128 | New destination vector |

## Verification
The bench sweeps every legal shift for all four variants of both sizes. It uses all-ones lanes, which make rounding carry out of the narrow half. If such a design kept that carry or saturated, it would return ones where zero is expected, and at the full-width shift it would also get the rounding bit wrong. Random predicates catch a design that indexes the predicate by the written byte rather than by input lane: such a design would drop or write the wrong top-half bytes. Sweeps with a random old destination and a zero source expose any untargeted element that is overwritten instead of merged.

// File: rtl/vnarrow_shr.sv
module vnarrow_shr #(
  parameter int VEC_W = 128,
  parameter int SH_W  = 5
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   dst_old,
  input  logic [SH_W-1:0]    shamt,
  input  logic               wide32,
  input  logic               top,
  input  logic               rnd,
  input  logic [VEC_W/8-1:0] pred,
  output logic [VEC_W-1:0]   result
);
  localparam int NB = VEC_W / 8;
  localparam int NH = VEC_W / 16;
  localparam int NW = VEC_W / 32;

  logic [7:0]       nb [NH];
  logic [15:0]      nh [NW];
  logic [VEC_W-1:0] nxt;

  // 16-bit lanes to bytes: keep one guard bit below the shifted value
  for (genvar i = 0; i < NH; i++) begin : g_h2b
    logic [8:0] t;
    assign t     = 9'({src[16*i +: 16], 1'b0} >> shamt);
    assign nb[i] = t[8:1] + 8'(t[0] & rnd);
  end

  // 32-bit lanes to halfwords
  for (genvar i = 0; i < NW; i++) begin : g_w2h
    logic [16:0] t;
    assign t     = 17'({src[32*i +: 32], 1'b0} >> shamt);
    assign nh[i] = t[16:1] + 16'(t[0] & rnd);
  end

  // per-byte placement, predicate and merge
  for (genvar j = 0; j < NB; j++) begin : g_byte
    localparam int L8  = j / 2;
    localparam bit P8  = (j % 2) == 1;
    localparam int L16 = j / 4;
    localparam bit P16 = ((j / 2) % 2) == 1;
    localparam int B16 = j % 2;
    logic       w;
    logic [7:0] v;
    assign v = wide32 ? nh[L16][8*B16 +: 8] : nb[L8];
    assign w = wide32 ? ((top == P16) && pred[4*L16 + B16])
                      : ((top == P8)  && pred[2*L8]);
    assign nxt[8*j +: 8] = w ? v : dst_old[8*j +: 8];
  end

  logic unused_pred_bits;
  assign unused_pred_bits = ^pred;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) result <= '0;
    else        result <= nxt;

endmodule

// File: rtl/vnarrow_shr_chk.sv
module vnarrow_shr_chk #(
  parameter int VEC_W = 128,
  parameter int SH_W  = 5
)(
  input logic               clk,
  input logic               rst_n,
  input logic [VEC_W-1:0]   src,
  input logic [VEC_W-1:0]   dst_old,
  input logic [SH_W-1:0]    shamt,
  input logic               wide32,
  input logic               top,
  input logic               rnd,
  input logic [VEC_W/8-1:0] pred,
  input logic [VEC_W-1:0]   result
);
  logic             armed;
  logic [VEC_W-1:0] keep;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  always_comb
    for (int j = 0; j < VEC_W/8; j++)
      keep[8*j +: 8] = ((wide32 ? ((j/2) % 2 == 1) : (j % 2 == 1)) != top) ? 8'hFF : 8'h00;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> result == '0);

  // R7
  untouched_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((result ^ $past(dst_old)) & $past(keep)) == '0);

  // R8
  pred_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(pred) == '0 |-> result == $past(dst_old));

  // R5
  trunc_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(!rnd && !wide32 && !top && pred[0]) |->
      result[7:0] == $past(8'(src[15:0] >> shamt)));

  // R6
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(rnd && !wide32 && !top && pred[0]) |->
      8'(result[7:0] - $past(8'(src[15:0] >> shamt))) <= 8'd1);
endmodule

bind vnarrow_shr vnarrow_shr_chk #(.VEC_W(VEC_W), .SH_W(SH_W)) u_chk (.*);

// File: tb/tb_vnarrow_shr.sv
`timescale 1ns/1ps
module tb_vnarrow_shr;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src = '0, dst_old = '0, result;
  logic [4:0]   shamt = '0;
  logic         wide32 = 1'b0, top = 1'b0, rnd = 1'b0;
  logic [15:0]  pred = '0;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  vnarrow_shr dut (.clk(clk), .rst_n(rst_n), .src(src), .dst_old(dst_old),
                   .shamt(shamt), .wide32(wide32), .top(top), .rnd(rnd),
                   .pred(pred), .result(result));

  function automatic logic [127:0] model(logic [127:0] s, logic [127:0] d,
      int sh, bit w, bit t, bit r, logic [15:0] p);
    logic [127:0] o = d;
    int lsz = w ? 4 : 2;
    int esz = w ? 2 : 1;
    for (int i = 0; i < 16 / lsz; i++) begin
      longint unsigned x = w ? longint'(s[32*i +: 32]) : longint'(s[16*i +: 16]);
      longint unsigned v = x >> sh;
      if (r && sh > 0) v = v + ((x >> (sh - 1)) & 1);
      for (int b = 0; b < esz; b++)
        if (p[i*lsz + b]) o[8*((2*i + int'(t))*esz + b) +: 8] = 8'(v >> (8*b));
    end
    return o;
  endfunction

  task automatic check(string tag, logic [127:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (w=%0d t=%0d r=%0d sh=%0d p=%h)",
               tag, result, exp, wide32, top, rnd, shamt, pred);
    end
  endtask

  task automatic run(string tag, logic [127:0] s, logic [127:0] d, int sh,
                     bit w, bit t, bit r, logic [15:0] p);
    @(negedge clk);
    src = s; dst_old = d; shamt = 5'(sh); wide32 = w; top = t; rnd = r; pred = p;
    @(negedge clk);
    check(tag, model(s, d, sh, w, t, r, p));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] pat [4];
    logic [127:0] hold;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0);

    // R2: operands change between edges, output holds
    run("R2", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, '0, 4, 1'b0, 1'b0, 1'b0, 16'hFFFF);
    hold = result;
    src = rnd128(); dst_old = rnd128(); #1;
    check("R2", hold);

    pat[0] = '1;
    pat[1] = {8{16'h8000}};
    pat[2] = rnd128();
    pat[3] = rnd128();
    // R5 truncating / R6 rounding, every legal shift, both sizes, both halves
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 2; r++)
          for (int sh = 1; sh <= (w ? 16 : 8); sh++)
            for (int k = 0; k < 4; k++)
              run(r ? "R6" : "R5", pat[k], rnd128(), sh, 1'(w), 1'(t), 1'(r), 16'hFFFF);

    // R3 lane size split, R4 placement
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 8; k++) begin
          run("R3", rnd128(), '0, 3, 1'(w), 1'(t), 1'b0, 16'hFFFF);
          run("R4", rnd128(), '1, 1, 1'(w), 1'(t), 1'b1, 16'hFFFF);
        end

    // R7 untargeted elements merged from old destination
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 8; k++)
          run("R7", '0, rnd128(), 2, 1'(w), 1'(t), 1'b0, 16'hFFFF);

    // R8 predicate indexed by input lane
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 2; r++)
          for (int k = 0; k < 20; k++)
            run("R8", rnd128(), rnd128(), 1 + int'($urandom % (w ? 16 : 8)),
                1'(w), 1'(t), 1'(r), 16'($urandom));
    run("R8", rnd128(), rnd128(), 5, 1'b1, 1'b1, 1'b1, 16'h0000);
    run("R8", '1, '0, 1, 1'b0, 1'b1, 1'b0, 16'h5555);
    run("R8", '1, '0, 1, 1'b1, 1'b0, 1'b0, 16'h3333);

    // R9 zero shift
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 2; r++)
        run("R9", rnd128(), rnd128(), 0, 1'(w), 1'b0, 1'(r), 16'hFFFF);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule